// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer of one core's local interrupt controller. Software programs three registers. An initial-count register starts, restarts or stops the countdown. A divide register sets how many clocks pass per decrement. A timer vector entry gives the interrupt vector, a mask bit and a mode. The running count can be read at any time from a port.

A non-zero initial count loads the running count and starts the timer. When the count runs out, the timer raises a one-cycle interrupt request that carries the entry's vector, unless the entry is masked. What happens after expiry depends on the mode. In periodic mode the count reloads and the timer runs again. In one-shot mode the count stays at zero. In deadline mode the initial-count writes have no effect and the countdown is frozen. Comparing against a timestamp counter is not part of this block, and neither is arbitration of the request.

Top module: `lapic_tmr`

## Requirements
- R1: After reset the current count is 0, no interrupt request is raised, the divide shift is 1 and the vector entry is masked, so a countdown started before the entry is written expires silently.
- R2: Writing the initial count, when not in deadline mode, sets the current count to the written value on the next cycle. A non-zero value starts counting. Zero stops the timer, leaves the count at 0 and cancels an expiry in the same cycle.
- R3: While running, the count falls by one every 2^s clocks. Here s is decoded from divide bits {3,1,0} as 000→1, 001→2, 010→3, 011→4, 100→5, 101→6, 110→7 and 111→0. Bit 2 is ignored. An interrupt that is not reloaded appears N·2^s cycles after a write of N.
- R4: On expiry with the entry unmasked, irq_req is high for one cycle and irq_vector carries entry bits 7:0 as they were in the cycle of expiry.
- R5: With entry bit 16 (mask) set, expiry raises no request, but the count behaves exactly as when unmasked.
- R6: In periodic mode (entry bits 18:17 = 01), expiry reloads the count from the initial count and restarts, so requests repeat every N·2^s cycles.
- R7: In one-shot mode (bits 18:17 = 00, and also the reserved code 11), expiry leaves the count at 0 and the timer stopped.
- R8: In deadline mode (bits 18:17 = 10, available when DEADLINE_EN is set), writes to the initial count are ignored and the count holds. When the mode returns to one-shot, counting resumes from the held value with a fresh divider phase.
- R9: Writing a new non-zero initial count while the timer runs restarts the countdown from the new value. The pending expiry of the old count is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| icount_we | input | 1 | Initial-count write strobe |
| icount_wdata | input | CNT_W | Initial-count write value |
| divcfg_we | input | 1 | Divide register write strobe |
| divcfg_wdata | input | 4 | Divide register write value |
| entry_we | input | 1 | Timer vector entry write strobe |
| entry_wdata | input | 32 | Entry value: vector 7:0, mask 16, mode 18:17 |
| cur_count | output | CNT_W | Current count |
| irq_req | output | 1 | Edge-type interrupt request, one cycle per expiry |
| irq_vector | output | 8 | Vector sent with the request |

## Verification
The assertions assume that every write strobe and its data are known values from the first cycle after reset. They also assume that an expiry is only judged through the registered mode and mask, so an entry write takes effect one cycle later. The step-size check assumes that only a write or an expiry at a count of 1 can move the count by more than one. The bench drives every write as a single-cycle strobe on the falling edge, always with defined data. It changes the mode to deadline only while the count is well above 1. A scoreboard queue holds the cycle and vector expected for each request, and any request that is not in the queue is reported.

// File: rtl/lapic_tmr_pkg.sv
// Shared types and helpers for the local interrupt countdown timer.
// Assumes a 32-bit vector entry with mode in 18:17, mask in 16, vector in 7:0.
package lapic_tmr_pkg;

    localparam int ENTRY_W  = 32;
    localparam int VEC_W    = 8;
    localparam int MODE_LSB = 17;
    localparam int MASK_BIT = 16;
    localparam int SHIFT_W  = 3;

    typedef enum logic [1:0] {
        TM_ONESHOT  = 2'b00,
        TM_PERIODIC = 2'b01,
        TM_DEADLINE = 2'b10,
        TM_RSVD     = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e          mode;
        logic               mask;
        logic [VEC_W-1:0]   vec;
    } entry_t;

    // Map divide bits {3,1,0} to a shift: code+1 modulo 8 (111 -> 0).
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] d);
        logic [SHIFT_W-1:0] code;
        code = {d[3], d[1], d[0]};
        return code + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/lapic_tmr_cfg.sv
// Configuration registers: timer vector entry and divide setting.
// Assumes single-cycle write strobes. With DEADLINE_EN clear, the upper
// mode bit is dropped on write, so deadline mode can never be selected.
module lapic_tmr_cfg
    import lapic_tmr_pkg::*;
#(
    parameter bit DEADLINE_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 divcfg_we,
    input  logic [3:0]           divcfg_wdata,
    input  logic                 entry_we,
    input  logic [ENTRY_W-1:0]   entry_wdata,
    output entry_t               entry,
    output logic [SHIFT_W-1:0]   shift
);

    logic [3:0] div_q;
    entry_t     entry_q;

    // Hold the divide setting; reset gives a shift of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= '0;
        else if (divcfg_we) div_q <= divcfg_wdata;
    end

    // Hold the vector entry; reset leaves it masked, one-shot, vector 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q.mode <= TM_ONESHOT;
            entry_q.mask <= 1'b1;
            entry_q.vec  <= '0;
        end else if (entry_we) begin
            entry_q.mode <= tmr_mode_e'({entry_wdata[MODE_LSB+1] & DEADLINE_EN,
                                         entry_wdata[MODE_LSB]});
            entry_q.mask <= entry_wdata[MASK_BIT];
            entry_q.vec  <= entry_wdata[VEC_W-1:0];
        end
    end

    // Decode the stored divide bits into a shift amount.
    always_comb shift = div_to_shift(div_q);

    assign entry = entry_q;

endmodule

// File: rtl/lapic_tmr_prescale.sv
// Prescaler: gives one tick every 2^shift clocks while run is high.
// Assumes clear restarts the phase; a stopped timer keeps the phase at 0.
module lapic_tmr_prescale
    import lapic_tmr_pkg::*;
#(
    parameter int SH_W = SHIFT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SH_W-1:0]  shift,
    output logic             tick
);

    localparam int PRE_W = (1 << SH_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] lim;

    // Terminal phase value for the selected shift.
    always_comb begin
        span = (PRE_W+1)'(1) << shift;
        lim  = PRE_W'(span - (PRE_W+1)'(1));
        tick = run && (pre_q >= lim);
    end

    // Advance the phase counter; wrap on a tick, zero when idle or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pre_q <= '0;
        else if (clear || !run || tick)  pre_q <= '0;
        else                             pre_q <= pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/lapic_tmr_core.sv
// Countdown core: holds the initial and current count, runs the mode
// dependent expiry and registers the interrupt request.
// Assumes a load and an expiry in one cycle resolve in favour of the load.
module lapic_tmr_core
    import lapic_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [CNT_W-1:0]  ld_val,
    input  entry_t            entry,
    input  logic              tick,
    output logic              run,
    output logic              restart,
    output logic [CNT_W-1:0]  cur_count,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cur_q;
    logic             running_q;
    logic             frozen;
    logic             step;
    logic             expire;

    // Qualify loads and count steps against the current mode.
    always_comb begin
        frozen  = (entry.mode == TM_DEADLINE);
        restart = ld_we && !frozen;
        run     = running_q && !frozen;
        step    = run && tick;
        expire  = step && (cur_q == CNT_W'(1));
    end

    // Keep the initial count for periodic reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)       init_q <= '0;
        else if (restart) init_q <= ld_val;
    end

    // Load, decrement, reload or park the current count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            running_q <= 1'b0;
        end else if (restart) begin
            cur_q     <= ld_val;
            running_q <= |ld_val;
        end else if (expire) begin
            if (entry.mode == TM_PERIODIC) begin
                cur_q     <= init_q;
                running_q <= |init_q;
            end else begin
                cur_q     <= '0;
                running_q <= 1'b0;
            end
        end else if (step) begin
            cur_q <= cur_q - CNT_W'(1);
        end
    end

    // Register the one-cycle request and its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req    <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_req <= expire && !restart && !entry.mask;
            if (expire) irq_vector <= entry.vec;
        end
    end

    assign cur_count = cur_q;

endmodule

// File: rtl/lapic_tmr.sv
// Top of the local interrupt countdown timer: configuration registers,
// prescaler and countdown core. Assumes one write strobe per register.
module lapic_tmr
    import lapic_tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter bit DEADLINE_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                icount_we,
    input  logic [CNT_W-1:0]    icount_wdata,
    input  logic                divcfg_we,
    input  logic [3:0]          divcfg_wdata,
    input  logic                entry_we,
    input  logic [ENTRY_W-1:0]  entry_wdata,
    output logic [CNT_W-1:0]    cur_count,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vector
);

    entry_t               lvt;
    logic [SHIFT_W-1:0]   shift;
    logic                 tick;
    logic                 run;
    logic                 restart;
    logic [1:0]           lvt_mode;
    logic                 lvt_mask;
    logic [VEC_W-1:0]     lvt_vec;

    lapic_tmr_cfg #(.DEADLINE_EN(DEADLINE_EN)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .divcfg_we    (divcfg_we),
        .divcfg_wdata (divcfg_wdata),
        .entry_we     (entry_we),
        .entry_wdata  (entry_wdata),
        .entry        (lvt),
        .shift        (shift)
    );

    lapic_tmr_prescale #(.SH_W(SHIFT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (restart),
        .shift (shift),
        .tick  (tick)
    );

    lapic_tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (icount_we),
        .ld_val     (icount_wdata),
        .entry      (lvt),
        .tick       (tick),
        .run        (run),
        .restart    (restart),
        .cur_count  (cur_count),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    // Split the entry fields for observation by the checker.
    always_comb begin
        lvt_mode = lvt.mode;
        lvt_mask = lvt.mask;
        lvt_vec  = lvt.vec;
    end

endmodule

// File: rtl/lapic_tmr_chk.sv
// Temporal checks for the countdown timer, bound into the top module.
// Assumes write inputs are known from the first cycle after reset.
module lapic_tmr_chk #(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              icount_we,
    input  logic [CNT_W-1:0]  icount_wdata,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic              irq_req,
    input  logic [7:0]        irq_vector,
    input  logic [1:0]        mode,
    input  logic              masked,
    input  logic [7:0]        vec
);

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (icount_we && mode != 2'b10) |=> cur_count == $past(icount_wdata)); // R2

    AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (icount_we && mode != 2'b10 && icount_wdata == '0) |=> (cur_count == '0 && !irq_req)); // R2

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!icount_we && cur_count > CNT_W'(1)) |=>
        (cur_count == $past(cur_count) || cur_count == $past(cur_count) - CNT_W'(1))); // R3

    AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_vector == $past(vec)); // R4

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(masked)); // R5

    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(mode) != 2'b01) |-> cur_count == '0); // R7

    AST_DEADLINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> cur_count == $past(cur_count)); // R8

endmodule

bind lapic_tmr lapic_tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .icount_we    (icount_we),
    .icount_wdata (icount_wdata),
    .cur_count    (cur_count),
    .irq_req      (irq_req),
    .irq_vector   (irq_vector),
    .mode         (lvt_mode),
    .masked       (lvt_mask),
    .vec          (lvt_vec)
);

// File: tb/test_lapic_tmr.sv
`timescale 1ns/1ps
module test_lapic_tmr;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          icount_we = 1'b0;
    logic [CW-1:0] icount_wdata = '0;
    logic          divcfg_we = 1'b0;
    logic [3:0]    divcfg_wdata = '0;
    logic          entry_we = 1'b0;
    logic [31:0]   entry_wdata = '0;
    logic [CW-1:0] cur_count;
    logic          irq_req;
    logic [7:0]    irq_vector;

    always #2.5 clk = ~clk;

    lapic_tmr #(.CNT_W(CW)) i_lapic_tmr (
        .clk(clk), .rst_n(rst_n),
        .icount_we(icount_we), .icount_wdata(icount_wdata),
        .divcfg_we(divcfg_we), .divcfg_wdata(divcfg_wdata),
        .entry_we(entry_we), .entry_wdata(entry_wdata),
        .cur_count(cur_count), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    int unsigned cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        logic [7:0]  vec;
        string       req;
    } exp_t;
    exp_t expq[$];

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mk_entry(logic [1:0] m, logic msk, logic [7:0] v);
        return (32'(m) << 17) | (32'(msk) << 16) | 32'(v);
    endfunction

    task automatic push_exp(int unsigned at, logic [7:0] v, string req);
        exp_t e;
        e.at = at; e.vec = v; e.req = req;
        expq.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_icount(logic [CW-1:0] v);
        @(negedge clk); icount_we = 1'b1; icount_wdata = v;
        @(negedge clk); icount_we = 1'b0;
    endtask

    task automatic wr_div(logic [3:0] v);
        @(negedge clk); divcfg_we = 1'b1; divcfg_wdata = v;
        @(negedge clk); divcfg_we = 1'b0;
    endtask

    task automatic wr_entry(logic [31:0] v);
        @(negedge clk); entry_we = 1'b1; entry_wdata = v;
        @(negedge clk); entry_we = 1'b0;
    endtask

    // Monitor: pop the scoreboard on every request and compare cycle and vector.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && irq_req) begin
            if (expq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R5 unexpected request actual=vec %0h at %0d expected=none",
                         irq_vector, cyc);
            end else begin
                e = expq.pop_front();
                check({e.req, " cycle"}, 64'(cyc), 64'(e.at));
                check({e.req, " vector"}, 64'(irq_vector), 64'(e.vec));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned c0;
        logic [CW-1:0] held;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 count", 64'(cur_count), 64'd0);
        check("R1 irq", 64'(irq_req), 64'd0);
        // R1: reset entry is masked; shift 1 gives expiry after 4 cycles, silently
        wr_icount(2);
        idle(6);
        check("R1 silent expiry count", 64'(cur_count), 64'd0);

        // R3/R4/R7: shift 1, one-shot, vector 41
        wr_div(4'b0000);
        wr_entry(mk_entry(2'b00, 1'b0, 8'h41));
        wr_icount(5); c0 = cyc;
        check("R2 load", 64'(cur_count), 64'd5);
        push_exp(c0 + 10, 8'h41, "R4");
        idle(4);
        check("R3 mid count", 64'(cur_count), 64'd3);
        idle(6);
        check("R7 parked", 64'(cur_count), 64'd0);
        idle(4);
        check("R7 stays parked", 64'(cur_count), 64'd0);

        // R3: code 111 (bit 2 set but ignored) gives shift 0
        wr_div(4'b1111);
        wr_icount(3); c0 = cyc;
        push_exp(c0 + 3, 8'h41, "R3 shift0");
        idle(1);
        check("R3 shift0 step", 64'(cur_count), 64'd2);
        idle(2);
        check("R3 shift0 end", 64'(cur_count), 64'd0);

        // R3: code 110 gives shift 7
        wr_div(4'b1010);
        wr_icount(2); c0 = cyc;
        push_exp(c0 + 256, 8'h41, "R3 shift7");
        idle(128);
        check("R3 shift7 half", 64'(cur_count), 64'd1);
        idle(128);
        check("R3 shift7 end", 64'(cur_count), 64'd0);

        // R6: periodic, shift 1, N=4
        wr_div(4'b0000);
        wr_entry(mk_entry(2'b01, 1'b0, 8'h77));
        wr_icount(4); c0 = cyc;
        push_exp(c0 + 8, 8'h77, "R6");
        push_exp(c0 + 16, 8'h77, "R6");
        push_exp(c0 + 24, 8'h77, "R6");
        idle(8);
        check("R6 reload", 64'(cur_count), 64'd4);
        idle(16);
        // R2: zero write stops the periodic timer
        wr_icount(0);
        check("R2 zero stop", 64'(cur_count), 64'd0);
        idle(20);
        check("R2 stays stopped", 64'(cur_count), 64'd0);

        // R5: masked one-shot still counts to zero, no request
        wr_entry(mk_entry(2'b00, 1'b1, 8'h55));
        wr_icount(3);
        idle(6);
        check("R5 masked count", 64'(cur_count), 64'd0);
        idle(4);

        // R9: rewrite while running restarts from the new value
        wr_entry(mk_entry(2'b00, 1'b0, 8'h12));
        wr_icount(10);
        idle(6);
        wr_icount(3); c0 = cyc;
        push_exp(c0 + 6, 8'h12, "R9");
        check("R9 reload", 64'(cur_count), 64'd3);
        idle(6);
        check("R9 end", 64'(cur_count), 64'd0);
        idle(20);

        // R8: deadline mode freezes count and ignores initial-count writes
        wr_icount(20);
        idle(4);
        wr_entry(mk_entry(2'b10, 1'b0, 8'h12));
        held = cur_count;
        idle(10);
        check("R8 hold", 64'(cur_count), 64'(held));
        wr_icount(7);
        check("R8 write ignored", 64'(cur_count), 64'(held));
        wr_entry(mk_entry(2'b00, 1'b0, 8'h12)); c0 = cyc;
        push_exp(c0 + 2 * held, 8'h12, "R8 resume");
        idle(2 * held + 10);
        check("R8 resume end", 64'(cur_count), 64'd0);

        idle(20);
        check("R4 all requests seen", 64'(expq.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule